// File: doc/BRIEF.md
# Resistive Touch Panel Scan Sequencer

This block runs the whole scan of a 4-wire resistive touch panel in hardware. A pen interrupt wakes it. It then issues a fixed series of register writes to the panel's touch control register and to the converter's control register. It waits the settle times, polls the conversion result for its valid flag, and measures X position, Y position and pressure in that order. Next it switches the panel back to interrupt mode, waits the pen-detect interval and reads the pen flags.

If the pen is still down, the block emits a sample event carrying x, y and pressure. It then waits the pen-detect interval again and rescans. If the pen is up, it emits a release event, but only when the previous pass produced a sample. After that it rearms and goes idle until the next wake.

Both data paths at the block's edge are valid/ready streams. The register-write stream (`rw_*`) holds its select and data stable while `rw_ready_i` is low, and the sequencer does nothing else until the write is taken. The event stream (`ev_*`) holds its payload stable while `ev_ready_i` is low, and no register write is issued until the event is accepted. The converter result `adc_word_i` and the pen flags are plain level inputs sampled by the block.

Top module: `touch_scan_seq`

## Requirements
- R1: After reset, `rw_valid_o` and `ev_valid_o` are low and `armed_o` is high.
- R2: One scan issues exactly 16 writes, in this order (sel 0 = touch control, sel 1 = converter control):
  - (1, 0x8000)
  - (0, 0x0912) twice, then (0, 0x0A12)
  - (1, 0x8008), (1, 0x8088)
  - (0, 0x0948) twice, then (0, 0x0A48)
  - (1, 0x8000), (1, 0x8080)
  - (0, 0x09C3)
  - (1, 0x8008), (1, 0x8088)
  - (1, 0x0000), (0, 0x00C3)
- R2 encodings: touch word bits 0-3 power the MX/PX/MY/PY plates and bits 4-7 ground them. Bits 9:8 are the mode (0 interrupt, 1 pressure, 2 position) and bit 11 is bias. In the converter word, bit 15 is enable, bit 7 is start, bits 4:2 select the channel (PX 0, PY 2) and bit 0 is sync, which is set when ADC_SYNC is 1.
- R3: After each write with the start bit, the block waits until bit 15 of `adc_word_i` is high. It stores bits 9:0 as the result of that conversion: first X, then Y, then pressure. Bits 14:10 are discarded.
- R4: At least `settle_us_i*CLK_PER_US` cycles pass between each position-mode write and the following write. At least `press_us_i*CLK_PER_US` cycles pass between the pressure-mode write and the following write.
- R5: After the last write of a scan, at least PEN_WAIT_US*CLK_PER_US cycles pass before the pen flags are sampled.
- R6: With both `pen_flags_i` bits low, the block emits an event with `ev_release_o`=0 and the three stored results. After it is accepted and the pen-detect interval has passed, it scans again.
- R7: With any `pen_flags_i` bit high, the block emits an event with `ev_release_o`=1 and x, y and pressure all zero, but only if the previous pass emitted a sample. Otherwise it emits nothing. In both cases it then returns to idle with `armed_o` high.
- R8: While `ev_valid_o` is high and `ev_ready_i` low, the event payload stays stable and no register write is offered.
- R9: While `rw_valid_o` is high and `rw_ready_i` low, `rw_valid_o`, `rw_sel_o` and `rw_data_o` stay stable.
- R10: `wake_i` starts a scan only while `armed_o` is high; a wake during a scan adds no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_i | input | 1 | Pen interrupt, starts a scan when armed |
| settle_us_i | input | 8 | Settle time before a position read, in µs |
| press_us_i | input | 8 | Settle time before the pressure read, in µs |
| pen_flags_i | input | 2 | Pen-up flags read from the panel |
| adc_word_i | input | 16 | Converter data word, bit 15 valid, bits 9:0 result |
| rw_valid_o | output | 1 | Register write offered |
| rw_ready_i | input | 1 | Register write taken |
| rw_sel_o | output | 1 | 0 touch control, 1 converter control |
| rw_data_o | output | 16 | Register write value |
| armed_o | output | 1 | Idle and waiting for a wake |
| ev_valid_o | output | 1 | Event offered |
| ev_ready_i | input | 1 | Event taken |
| ev_release_o | output | 1 | 1 release event, 0 sample event |
| ev_x_o | output | 10 | X result |
| ev_y_o | output | 10 | Y result |
| ev_p_o | output | 10 | Pressure result |

## Verification
The bench drives four patterns:

- A touch held across two scans and then lifted. This tells apart correct write words and order, result capture with junk in the upper bits, settle gaps, and release after a sample.
- A wake with the pen already up. This separates the no-release path from the release path, and it also sends a second wake mid-scan to show that it is ignored.
- A touch whose event is held back by a low `ev_ready_i`. This shows the stall and the payload hold.
- A register-write ready that toggles throughout every run. The bench compares each stalled write against the next cycle to show the write stream holds its value.

// File: rtl/tss_pkg.sv
`timescale 1ns/1ps
package tss_pkg;
  localparam int WORD_W = 16;
  localparam int RES_W  = 10;
  localparam int STEP_W = 4;

  // touch control word fields
  localparam logic [WORD_W-1:0] T_MX_PWR = 16'h0001;
  localparam logic [WORD_W-1:0] T_PX_PWR = 16'h0002;
  localparam logic [WORD_W-1:0] T_PY_PWR = 16'h0008;
  localparam logic [WORD_W-1:0] T_MX_GND = 16'h0010;
  localparam logic [WORD_W-1:0] T_MY_GND = 16'h0040;
  localparam logic [WORD_W-1:0] T_PY_GND = 16'h0080;
  localparam logic [WORD_W-1:0] T_MODE_INT = 16'h0000;
  localparam logic [WORD_W-1:0] T_MODE_PRS = 16'h0100;
  localparam logic [WORD_W-1:0] T_MODE_POS = 16'h0200;
  localparam logic [WORD_W-1:0] T_BIAS     = 16'h0800;

  // converter control word fields
  localparam logic [WORD_W-1:0] A_ENA   = 16'h8000;
  localparam logic [WORD_W-1:0] A_START = 16'h0080;
  localparam logic [2:0] CH_PX = 3'd0;
  localparam logic [2:0] CH_PY = 3'd2;
  localparam int VALID_BIT = 15;

  typedef enum logic [1:0] {ACT_NEXT, ACT_DELAY, ACT_POLL, ACT_PEN} act_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WRITE, S_DELAY, S_POLL, S_PENWAIT, S_EMIT, S_HOLD, S_REWAIT
  } state_e;

  typedef struct packed {
    logic              sel;
    logic [WORD_W-1:0] data;
    act_e              act;
    logic              use_press;
    logic [1:0]        slot;
  } step_t;

  typedef struct packed {
    logic             rel;
    logic [RES_W-1:0] x;
    logic [RES_W-1:0] y;
    logic [RES_W-1:0] p;
  } event_t;

  function automatic logic [WORD_W-1:0] adc_cfg(logic [2:0] ch, logic go, logic sync);
    adc_cfg = A_ENA | {11'd0, ch, 2'd0} | (go ? A_START : '0) | {15'd0, sync};
  endfunction

  function automatic step_t step_info(logic [STEP_W-1:0] s, logic sync);
    step_t r;
    logic [WORD_W-1:0] xplate, yplate;
    xplate = T_MX_GND | T_PX_PWR | T_BIAS;
    yplate = T_MY_GND | T_PY_PWR | T_BIAS;
    r = '{sel: 1'b0, data: '0, act: ACT_NEXT, use_press: 1'b0, slot: 2'd0};
    case (s)
      4'd0:  begin r.sel = 1'b1; r.data = A_ENA; end
      4'd1, 4'd2: r.data = xplate | T_MODE_PRS;
      4'd3:  begin r.data = xplate | T_MODE_POS; r.act = ACT_DELAY; end
      4'd4:  begin r.sel = 1'b1; r.data = adc_cfg(CH_PY, 1'b0, sync); end
      4'd5:  begin r.sel = 1'b1; r.data = adc_cfg(CH_PY, 1'b1, sync);
                   r.act = ACT_POLL; r.slot = 2'd0; end
      4'd6, 4'd7: r.data = yplate | T_MODE_PRS;
      4'd8:  begin r.data = yplate | T_MODE_POS; r.act = ACT_DELAY; end
      4'd9:  begin r.sel = 1'b1; r.data = adc_cfg(CH_PX, 1'b0, sync); end
      4'd10: begin r.sel = 1'b1; r.data = adc_cfg(CH_PX, 1'b1, sync);
                   r.act = ACT_POLL; r.slot = 2'd1; end
      4'd11: begin r.data = T_MX_PWR | T_PX_PWR | T_MY_GND | T_PY_GND | T_MODE_PRS | T_BIAS;
                   r.act = ACT_DELAY; r.use_press = 1'b1; end
      4'd12: begin r.sel = 1'b1; r.data = adc_cfg(CH_PY, 1'b0, sync); end
      4'd13: begin r.sel = 1'b1; r.data = adc_cfg(CH_PY, 1'b1, sync);
                   r.act = ACT_POLL; r.slot = 2'd2; end
      4'd14: begin r.sel = 1'b1; r.data = '0; end
      default: begin r.data = T_MX_PWR | T_PX_PWR | T_MY_GND | T_PY_GND | T_MODE_INT;
                     r.act = ACT_PEN; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tss_timer.sv
`timescale 1ns/1ps
module tss_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= load;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R4: a started non-zero wait is busy in the following cycle
  a_r4_timer_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (start && load != '0) |=> busy);
endmodule

// File: rtl/tss_result_bank.sv
`timescale 1ns/1ps
module tss_result_bank #(
  parameter int N = 3,
  parameter int W = 10,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_val,
  output logic [N*W-1:0]   rd_flat
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [W-1:0] val;
    always_ff @(posedge clk) begin
      if (!rst_n)                                     val <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))          val <= wr_val;
    end
    assign rd_flat[g*W +: W] = val;
  end

  // R3: results change only on a completed conversion
  a_r3_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_flat));
endmodule

// File: rtl/tss_event_port.sv
`timescale 1ns/1ps
module tss_event_port #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && !out_valid) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign in_ready = !out_valid;

  // R8: a refused event is held unchanged
  a_r8_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/touch_scan_seq.sv
`timescale 1ns/1ps
module touch_scan_seq
  import tss_pkg::*;
#(
  parameter int CLK_PER_US  = 200,
  parameter int PEN_WAIT_US = 10000,
  parameter int ADC_SYNC    = 0,
  parameter int US_W        = 8,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_i,
  input  logic [US_W-1:0]   settle_us_i,
  input  logic [US_W-1:0]   press_us_i,
  input  logic [1:0]        pen_flags_i,
  input  logic [WORD_W-1:0] adc_word_i,
  output logic              rw_valid_o,
  input  logic              rw_ready_i,
  output logic              rw_sel_o,
  output logic [WORD_W-1:0] rw_data_o,
  output logic              armed_o,
  output logic              ev_valid_o,
  input  logic              ev_ready_i,
  output logic              ev_release_o,
  output logic [RES_W-1:0]  ev_x_o,
  output logic [RES_W-1:0]  ev_y_o,
  output logic [RES_W-1:0]  ev_p_o
);
  localparam logic [CNT_W-1:0] PEN_CYC = CNT_W'(PEN_WAIT_US * CLK_PER_US);
  localparam int EV_W = $bits(event_t);

  state_e            state;
  logic [STEP_W-1:0] step;
  logic              had_sample, rel_q;
  step_t             si;
  logic              wr_fire, leave_hold, tmr_start, tmr_busy;
  logic [CNT_W-1:0]  tmr_load, settle_cyc, press_cyc;
  logic              cap_en, push, push_ready;
  logic [3*RES_W-1:0] res_flat;
  event_t            push_ev, out_ev;

  assign si         = step_info(step, ADC_SYNC != 0);
  assign wr_fire    = (state == S_WRITE) && rw_ready_i;
  assign leave_hold = (state == S_HOLD) && !ev_valid_o;
  assign settle_cyc = CNT_W'(settle_us_i) * CNT_W'(CLK_PER_US);
  assign press_cyc  = CNT_W'(press_us_i) * CNT_W'(CLK_PER_US);

  always_comb begin
    tmr_start = 1'b0;
    tmr_load  = PEN_CYC;
    if (wr_fire && si.act == ACT_DELAY) begin
      tmr_start = 1'b1;
      tmr_load  = si.use_press ? press_cyc : settle_cyc;
    end else if (wr_fire && si.act == ACT_PEN) begin
      tmr_start = 1'b1;
    end else if (leave_hold && !rel_q) begin
      tmr_start = 1'b1;
    end
  end

  tss_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .load(tmr_load), .busy(tmr_busy)
  );

  assign cap_en = (state == S_POLL) && adc_word_i[VALID_BIT];

  tss_result_bank #(.N(3), .W(RES_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cap_en), .wr_idx(si.slot),
    .wr_val(adc_word_i[RES_W-1:0]), .rd_flat(res_flat)
  );

  assign push = (state == S_EMIT);
  always_comb begin
    if (rel_q) push_ev = '{rel: 1'b1, x: '0, y: '0, p: '0};
    else       push_ev = '{rel: 1'b0, x: res_flat[0 +: RES_W],
                           y: res_flat[RES_W +: RES_W], p: res_flat[2*RES_W +: RES_W]};
  end

  tss_event_port #(.W(EV_W)) u_evport (
    .clk(clk), .rst_n(rst_n), .in_valid(push), .in_ready(push_ready), .in_data(push_ev),
    .out_valid(ev_valid_o), .out_ready(ev_ready_i), .out_data(out_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      step       <= '0;
      had_sample <= 1'b0;
      rel_q      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (wake_i) begin
          step  <= '0;
          state <= S_WRITE;
        end
        S_WRITE: if (rw_ready_i) begin
          case (si.act)
            ACT_DELAY: state <= S_DELAY;
            ACT_POLL:  state <= S_POLL;
            ACT_PEN:   state <= S_PENWAIT;
            default:   step  <= step + 1'b1;
          endcase
        end
        S_DELAY: if (!tmr_busy) begin
          step  <= step + 1'b1;
          state <= S_WRITE;
        end
        S_POLL: if (adc_word_i[VALID_BIT]) begin
          step  <= step + 1'b1;
          state <= S_WRITE;
        end
        S_PENWAIT: if (!tmr_busy) begin
          if (|pen_flags_i) begin
            had_sample <= 1'b0;
            rel_q      <= 1'b1;
            state      <= had_sample ? S_EMIT : S_IDLE;
          end else begin
            had_sample <= 1'b1;
            rel_q      <= 1'b0;
            state      <= S_EMIT;
          end
        end
        S_EMIT: if (push_ready) state <= S_HOLD;
        S_HOLD: if (!ev_valid_o) state <= rel_q ? S_IDLE : S_REWAIT;
        S_REWAIT: if (!tmr_busy) begin
          step  <= '0;
          state <= S_WRITE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rw_valid_o   = (state == S_WRITE);
  assign rw_sel_o     = si.sel;
  assign rw_data_o    = si.data;
  assign armed_o      = (state == S_IDLE);
  assign ev_release_o = out_ev.rel;
  assign ev_x_o       = out_ev.x;
  assign ev_y_o       = out_ev.y;
  assign ev_p_o       = out_ev.p;

  // R9: a refused register write is held unchanged
  a_r9_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_valid_o && !rw_ready_i) |=> (rw_valid_o && $stable(rw_data_o) && $stable(rw_sel_o)));

  // R8: no register write while an event waits
  a_r8_no_write_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_o |-> !rw_valid_o);

  // R10: a wake while armed leaves the armed state
  a_r10_wake_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && wake_i) |=> !armed_o);

  // R7: a release event carries zero coordinates
  a_r7_release_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && ev_release_o) |-> (ev_x_o == '0 && ev_y_o == '0 && ev_p_o == '0));
endmodule

// File: tb/tb_touch_scan_seq.sv
`timescale 1ns/1ps
module tb_touch_scan_seq;
  localparam int CPU = 2;
  localparam int PW  = 20;
  localparam int SETTLE = 3;
  localparam int PRESS  = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake = 1'b0;
  logic [1:0] pen_flags = 2'b11;
  logic [15:0] adc_word = 16'h0;
  logic rw_ready = 1'b0;
  logic ev_ready = 1'b0;
  logic rw_valid, rw_sel, armed, ev_valid, ev_rel;
  logic [15:0] rw_data;
  logic [9:0] ev_x, ev_y, ev_p;

  always #2.5 clk = ~clk;

  touch_scan_seq #(.CLK_PER_US(CPU), .PEN_WAIT_US(PW)) dut (
    .clk(clk), .rst_n(rst_n), .wake_i(wake),
    .settle_us_i(8'(SETTLE)), .press_us_i(8'(PRESS)),
    .pen_flags_i(pen_flags), .adc_word_i(adc_word),
    .rw_valid_o(rw_valid), .rw_ready_i(rw_ready), .rw_sel_o(rw_sel), .rw_data_o(rw_data),
    .armed_o(armed), .ev_valid_o(ev_valid), .ev_ready_i(ev_ready),
    .ev_release_o(ev_rel), .ev_x_o(ev_x), .ev_y_o(ev_y), .ev_p_o(ev_p)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int cyc = 0;
  bit ev_rdy_en = 1'b1;
  logic [9:0] xv, yv, pv;

  int wr_n = 0;
  logic        wl_sel [256];
  logic [15:0] wl_dat [256];
  int          wl_cyc [256];
  int ev_n = 0;
  logic        el_rel [32];
  logic [9:0]  el_x [32], el_y [32], el_p [32];
  int          el_cyc [32];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] exp_word(int k);
    case (k)
      0: return {1'b1, 16'h8000};
      1, 2: return {1'b0, 16'h0912};
      3: return {1'b0, 16'h0A12};
      4: return {1'b1, 16'h8008};
      5: return {1'b1, 16'h8088};
      6, 7: return {1'b0, 16'h0948};
      8: return {1'b0, 16'h0A48};
      9: return {1'b1, 16'h8000};
      10: return {1'b1, 16'h8080};
      11: return {1'b0, 16'h09C3};
      12: return {1'b1, 16'h8008};
      13: return {1'b1, 16'h8088};
      14: return {1'b1, 16'h0000};
      default: return {1'b0, 16'h00C3};
    endcase
  endfunction

  // environment: ready pattern, converter model, stream monitors
  initial begin
    int busy = 0, conv_n = 0;
    bit stall = 0;
    logic [16:0] held = '0;
    forever begin
      @(negedge clk);
      cyc++;
      rw_ready = (cyc % 3) != 1;
      ev_ready = ev_rdy_en;
      if (busy > 0) begin
        busy--;
        if (busy == 0)
          adc_word = 16'hFC00 | {6'd0, (conv_n == 1) ? xv : (conv_n == 2) ? yv : pv};
      end
      #1;
      if (rst_n && stall)  // R9
        check(rw_valid && {rw_sel, rw_data} == held, "R9 write hold", {rw_sel, rw_data}, held);
      stall = rst_n && rw_valid && !rw_ready;
      held  = {rw_sel, rw_data};
      if (rst_n && rw_valid && rw_ready) begin
        wl_sel[wr_n] = rw_sel; wl_dat[wr_n] = rw_data; wl_cyc[wr_n] = cyc;
        wr_n++;
        if (rw_sel && rw_data == 16'h0) conv_n = 0;
        if (rw_sel && rw_data[7]) begin
          conv_n++;
          busy = 4;
          adc_word = 16'h0;
        end
      end
      if (rst_n && ev_valid && ev_ready) begin
        el_rel[ev_n] = ev_rel; el_x[ev_n] = ev_x; el_y[ev_n] = ev_y; el_p[ev_n] = ev_p;
        el_cyc[ev_n] = cyc;
        ev_n++;
      end
    end
  end

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
  endtask

  task automatic wait_events(int n, string req);
    for (int i = 0; i < 4000 && ev_n < n; i++) begin
      @(negedge clk); #2;
    end
    check(ev_n >= n, req, ev_n, n);
  endtask

  task automatic wait_armed(string req);
    for (int i = 0; i < 4000 && !armed; i++) begin
      @(negedge clk); #2;
    end
    check(armed, req, armed, 1);
  endtask

  task automatic check_scan(int base, string tag);
    for (int k = 0; k < 16; k++)
      check({wl_sel[base+k], wl_dat[base+k]} == exp_word(k), tag,
            {wl_sel[base+k], wl_dat[base+k]}, exp_word(k));
  endtask

  task automatic t_reset();
    @(negedge clk); #2;
    check(!rw_valid, "R1 rw_valid", rw_valid, 0);
    check(!ev_valid, "R1 ev_valid", ev_valid, 0);
    check(armed, "R1 armed", armed, 1);
  endtask

  task automatic t_touch_then_lift();
    int base = wr_n, e0 = ev_n;
    xv = 10'h123; yv = 10'h2AB; pv = 10'h05C;
    pen_flags = 2'b00;
    pulse_wake();
    wait_events(e0 + 1, "R6 sample event");
    check_scan(base, "R2 scan words");
    check(el_rel[e0] == 1'b0, "R6 kind", el_rel[e0], 0);
    check(el_x[e0] == xv, "R3 x masked", el_x[e0], xv);
    check(el_y[e0] == yv, "R3 y masked", el_y[e0], yv);
    check(el_p[e0] == pv, "R3 p masked", el_p[e0], pv);
    check(wl_cyc[base+4] - wl_cyc[base+3] >= SETTLE*CPU, "R4 x settle",
          wl_cyc[base+4] - wl_cyc[base+3], SETTLE*CPU);
    check(wl_cyc[base+9] - wl_cyc[base+8] >= SETTLE*CPU, "R4 y settle",
          wl_cyc[base+9] - wl_cyc[base+8], SETTLE*CPU);
    check(wl_cyc[base+12] - wl_cyc[base+11] >= PRESS*CPU, "R4 press settle",
          wl_cyc[base+12] - wl_cyc[base+11], PRESS*CPU);
    check(el_cyc[e0] - wl_cyc[base+15] >= PW*CPU, "R5 pen wait",
          el_cyc[e0] - wl_cyc[base+15], PW*CPU);
    pen_flags = 2'b10;
    wait_events(e0 + 2, "R7 release event");
    check(wr_n - base == 32, "R6 rescan writes", wr_n - base, 32);
    check_scan(base + 16, "R2 rescan words");
    check(el_rel[e0+1] == 1'b1, "R7 kind", el_rel[e0+1], 1);
    check(el_x[e0+1] == 0 && el_y[e0+1] == 0 && el_p[e0+1] == 0, "R7 zero fields",
          {el_x[e0+1], el_y[e0+1], el_p[e0+1]}, 0);
    wait_armed("R7 rearmed");
  endtask

  task automatic t_no_touch();
    int base = wr_n, e0 = ev_n;
    pen_flags = 2'b01;
    pulse_wake();
    repeat (6) @(negedge clk);
    pulse_wake();  // R10: mid-scan wake
    for (int i = 0; i < 4000 && wr_n - base < 16; i++) @(negedge clk);
    wait_armed("R7 armed after empty scan");
    repeat (80) @(negedge clk);
    #2;
    check(wr_n - base == 16, "R10 wake ignored", wr_n - base, 16);
    check(ev_n == e0, "R7 no release", ev_n, e0);
    check(armed, "R10 still armed", armed, 1);
  endtask

  task automatic t_backpressure();
    int e0 = ev_n, w0;
    logic [30:0] snap;
    xv = 10'h3FF; yv = 10'h000; pv = 10'h1A5;
    pen_flags = 2'b00;
    ev_rdy_en = 1'b0;
    pulse_wake();
    for (int i = 0; i < 4000 && !ev_valid; i++) begin
      @(negedge clk); #2;
    end
    check(ev_valid, "R8 event offered", ev_valid, 1);
    snap = {ev_rel, ev_x, ev_y, ev_p};
    w0 = wr_n;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #2;
      check(ev_valid && {ev_rel, ev_x, ev_y, ev_p} == snap, "R8 event hold",
            {ev_rel, ev_x, ev_y, ev_p}, snap);
    end
    check(wr_n == w0, "R8 stalled writes", wr_n - w0, 0);
    ev_rdy_en = 1'b1;
    wait_events(e0 + 1, "R8 accepted");
    check(el_x[e0] == xv && el_y[e0] == yv && el_p[e0] == pv, "R6 values after stall",
          {el_x[e0], el_y[e0], el_p[e0]}, {xv, yv, pv});
    pen_flags = 2'b11;
    wait_events(e0 + 2, "R7 release after stall");
    wait_armed("R7 rearmed after stall");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_touch_then_lift();
    t_no_touch();
    t_backpressure();
    finish_run();
  end
endmodule